// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. It watches the line while idle and arms on a low level. After half a bit time it looks again and accepts the start bit only if the line is still low. It then takes one sample per bit, a full bit time after the previous one, so every data, parity and stop bit is sampled near its centre. Data bits arrive least significant bit first.

A receive clock enable marks each tick of the receive clock. The tick rate is 1, 16 or 64 times the baud rate, as chosen by a factor input. Character length can be 5 to 8 bits, and an optional even or odd parity bit can follow the data. The finished character is placed in a buffer and a ready flag goes high. Parity, framing and overrun errors stay set until the host clears them. A host read of the buffer clears the ready flag.

Top module: `async_char_rx`

## Requirements
- R1: After reset, `rx_ready_o`, `parity_err_o`, `frame_err_o` and `overrun_err_o` are 0 and `data_o` is 0.
- R2: While `rxd_i` stays high, no character is received and `rx_ready_o` stays 0.
- R3: A low on the line that is gone by the half-bit check returns the receiver to idle. No character is produced. A correct frame that follows is received normally.
- R4: `char_len_i` selects 00=5, 01=6, 10=7 or 11=8 data bits. These are sampled least significant bit first and placed at `data_o[n-1:0]`. The unused upper bits read 0.
- R5: `clk_factor_i` selects ticks per bit: 00=1, 01=16, 10 or 11=64. With 16 or 64, the start check falls half a bit (8 or 32 ticks) after the low is seen, and each later sample comes a full bit after the previous one.
- R6: When `parity_en_i`=1, one parity bit follows the data. `parity_odd_i`=0 expects even parity over data plus parity bit, and 1 expects odd parity. A mismatch sets `parity_err_o`, and the character is still delivered.
- R7: A 0 at the first stop-bit sample sets `frame_err_o`. The character is still delivered.
- R8: `rx_ready_o` rises when a character completes. A one-cycle `read_i` pulse clears it on the next clock edge.
- R9: If a character completes while `rx_ready_o` is high and no read comes in that cycle, `overrun_err_o` is set. The new character replaces the old one.
- R10: The three error flags stay set through reads. They clear only on an `err_clr_i` pulse, which does not change `rx_ready_o`.
- R11: With factor x1, the start bit is confirmed at the first tick after the low is seen. Each later bit is sampled one tick after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Receive clock enable, one pulse per receive clock |
| rxd_i | input | 1 | Serial data line, idle high |
| char_len_i | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| parity_en_i | input | 1 | Parity bit present |
| parity_odd_i | input | 1 | 1 = odd parity, 0 = even |
| clk_factor_i | input | 2 | Ticks per bit: 00=1, 01=16, else 64 |
| read_i | input | 1 | Host read strobe for the data buffer |
| err_clr_i | input | 1 | Clears all error flags |
| data_o | output | 8 | Received character |
| rx_ready_o | output | 1 | Character waiting in buffer |
| parity_err_o | output | 1 | Sticky parity error |
| frame_err_o | output | 1 | Sticky framing error |
| overrun_err_o | output | 1 | Sticky overrun error |

## Verification
The line first passes through a two-stage synchronizer. A character's results then appear at the ports two clock cycles after the stop-bit sample tick: one cycle to register completion and one to load the buffer. That tick falls mid-way through the stop bit. The bench therefore checks data, ready and flags at a falling edge a few cycles after the whole stop bit has been sent, when every result must already be settled. Read and error-clear pulses are driven for one cycle and their effect is checked at the next falling edge, one register later.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned FULL_X16 = 16;
  localparam int unsigned FULL_X64 = 64;
  localparam int unsigned CNT_W    = $clog2(FULL_X64 + 1);
  localparam int unsigned IDX_W    = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  function automatic logic [CNT_W-1:0] full_ticks(input logic [1:0] fac);
    case (fac)
      2'b00:   return CNT_W'(1);
      2'b01:   return CNT_W'(FULL_X16);
      default: return CNT_W'(FULL_X64);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] half_ticks(input logic [1:0] fac);
    case (fac)
      2'b00:   return CNT_W'(1);
      2'b01:   return CNT_W'(FULL_X16 / 2);
      default: return CNT_W'(FULL_X64 / 2);
    endcase
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer import async_rx_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       arm_i,
  input  logic       run_i,
  input  logic [1:0] factor_i,
  output logic       sample_o
);
  logic [CNT_W-1:0] cnt_q;

  assign sample_o = run_i && tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (arm_i)    cnt_q <= half_ticks(factor_i);
    else if (sample_o) cnt_q <= full_ticks(factor_i);
    else if (run_i && tick_i) cnt_q <= cnt_q - CNT_W'(1);
  end

  assert_cnt_live_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q != '0));
  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FULL_X64));
endmodule

// File: rtl/rx_frame.sv
module rx_frame import async_rx_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              sample_i,
  input  logic [1:0]        len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              arm_o,
  output logic              run_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_err_o,
  output logic              frame_err_o
);
  rx_state_e         state_q, state_d;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              pbit_q;
  logic [IDX_W-1:0]  last_idx;
  logic [DATA_W-1:0] char_now;

  assign last_idx = IDX_W'(4) + IDX_W'(len_i);
  assign char_now = sh_q >> (IDX_W'(3) - IDX_W'(len_i));
  assign arm_o    = (state_q == ST_IDLE) && !rxd_i;
  assign run_o    = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (!rxd_i) state_d = ST_START;
      ST_START: if (sample_i) state_d = rxd_i ? ST_IDLE : ST_DATA;
      ST_DATA:  if (sample_i && idx_q == last_idx) state_d = par_en_i ? ST_PAR : ST_STOP;
      ST_PAR:   if (sample_i) state_d = ST_STOP;
      ST_STOP:  if (sample_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sh_q        <= '0;
      idx_q       <= '0;
      pbit_q      <= 1'b0;
      done_o      <= 1'b0;
      data_o      <= '0;
      par_err_o   <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= 1'b0;
      if (sample_i) begin
        case (state_q)
          ST_START: begin
            sh_q  <= '0;
            idx_q <= '0;
          end
          ST_DATA: begin
            sh_q  <= {rxd_i, sh_q[DATA_W-1:1]};
            idx_q <= idx_q + IDX_W'(1);
          end
          ST_PAR: pbit_q <= rxd_i;
          ST_STOP: begin
            done_o      <= 1'b1;
            data_o      <= char_now;
            par_err_o   <= par_en_i && (pbit_q != (^char_now ^ par_odd_i));
            frame_err_o <= !rxd_i;
          end
          default: ;
        endcase
      end
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && rxd_i) |=> (state_q == ST_IDLE));
  assert_false_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && sample_i && rxd_i) |=> (state_q == ST_IDLE && !done_o));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx import async_rx_pkg::*; #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [1:0]        char_len_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic [1:0]        clk_factor_i,
  input  logic              read_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rx_ready_o,
  output logic              parity_err_o,
  output logic              frame_err_o,
  output logic              overrun_err_o
);
  logic              rxd_s, arm, run, sample, done, perr, ferr;
  logic [DATA_W-1:0] char_d;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s)
  );

  rx_bit_timer u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .arm_i(arm), .run_i(run),
    .factor_i(clk_factor_i), .sample_o(sample)
  );

  rx_frame u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .rxd_i(rxd_s), .sample_i(sample),
    .len_i(char_len_i), .par_en_i(parity_en_i), .par_odd_i(parity_odd_i),
    .arm_o(arm), .run_o(run), .done_o(done), .data_o(char_d),
    .par_err_o(perr), .frame_err_o(ferr)
  );

  // set wins over clear; a read in the completion cycle avoids overrun
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o        <= '0;
      rx_ready_o    <= 1'b0;
      parity_err_o  <= 1'b0;
      frame_err_o   <= 1'b0;
      overrun_err_o <= 1'b0;
    end else begin
      if (done) begin
        data_o     <= char_d;
        rx_ready_o <= 1'b1;
      end else if (read_i) begin
        rx_ready_o <= 1'b0;
      end
      parity_err_o  <= (parity_err_o  && !err_clr_i) || (done && perr);
      frame_err_o   <= (frame_err_o   && !err_clr_i) || (done && ferr);
      overrun_err_o <= (overrun_err_o && !err_clr_i) || (done && rx_ready_o && !read_i);
    end
  end

  assert_rdy_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ready_o) |-> $past(done));
  assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && !done) |=> !rx_ready_o);
  assert_overrun_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && rx_ready_o && !read_i) |=> overrun_err_o);
  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_clr_i && (parity_err_o || frame_err_o)) |=>
      ($past(parity_err_o) -> parity_err_o) && ($past(frame_err_o) -> frame_err_o));
endmodule

// File: tb/async_char_rx_tb.sv
module async_char_rx_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i;
  logic       rxd_i = 1'b1;
  logic [1:0] char_len_i = 2'b11;
  logic       parity_en_i = 1'b0;
  logic       parity_odd_i = 1'b0;
  logic [1:0] clk_factor_i = 2'b01;
  logic       read_i = 1'b0;
  logic       err_clr_i = 1'b0;
  logic [7:0] data_o;
  logic       rx_ready_o, parity_err_o, frame_err_o, overrun_err_o;

  int checks = 0;
  int errors = 0;
  int div = 1;
  int tick_cnt = 0;

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i) tick_cnt <= (tick_cnt + 1 >= div) ? 0 : tick_cnt + 1;
  assign tick_i = (tick_cnt == 0);

  async_char_rx u_dut (
    .clk_i, .rst_ni, .tick_i, .rxd_i, .char_len_i, .parity_en_i, .parity_odd_i,
    .clk_factor_i, .read_i, .err_clr_i, .data_o, .rx_ready_o, .parity_err_o,
    .frame_err_o, .overrun_err_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ticks_per_bit(input logic [1:0] fac);
    return (fac == 2'b00) ? 1 : (fac == 2'b01) ? 16 : 64;
  endfunction

  function automatic logic [7:0] mask_char(input logic [7:0] d, input logic [1:0] len);
    return d & 8'(( 1 << (5 + len)) - 1);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic setup(input logic [1:0] fac);
    clk_factor_i = fac;
    div = (fac == 2'b00) ? 8 : 1;
    repeat (10) @(negedge clk_i);
    if (fac == 2'b00) while (tick_cnt != 3) @(negedge clk_i);
  endtask

  task automatic hold(input logic b, input int n);
    rxd_i = b;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    int bt;
    logic [7:0] m;
    bt = ticks_per_bit(clk_factor_i) * div;
    m = mask_char(d, char_len_i);
    hold(1'b0, bt);
    for (int i = 0; i < 5 + int'(char_len_i); i++) hold(m[i], bt);
    if (parity_en_i) hold(par_bit(m, parity_odd_i) ^ bad_par, bt);
    hold(!bad_stop, bt);
    hold(1'b1, 6);
  endtask

  task automatic pulse_read();
    read_i = 1'b1; @(negedge clk_i); read_i = 1'b0;
  endtask

  task automatic pulse_clr();
    err_clr_i = 1'b1; @(negedge clk_i); err_clr_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic bp, bs;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 ready", rx_ready_o, 0);
    chk("R1 flags", {parity_err_o, frame_err_o, overrun_err_o}, 0);
    chk("R1 data", data_o, 0);
    rst_ni = 1'b1;
    // R2 idle line
    hold(1'b1, 300);
    chk("R2 idle no char", rx_ready_o, 0);
    // R3 short low glitch at x16
    setup(2'b01);
    hold(1'b0, 5);
    hold(1'b1, 100);
    chk("R3 glitch no char", rx_ready_o, 0);
    send(8'hA5, 0, 0);
    chk("R3 frame after glitch ready", rx_ready_o, 1);
    chk("R3 frame after glitch data", data_o, 8'hA5);
    pulse_read();
    chk("R8 read clears ready", rx_ready_o, 0);
    // R4 five-bit character with upper bits discarded, x64
    setup(2'b10);
    char_len_i = 2'b00;
    send(8'hF6, 0, 0);
    chk("R4 5-bit data", data_o, 8'h16);
    chk("R5 x64 ready", rx_ready_o, 1);
    pulse_read();
    // R11 x1 factor
    setup(2'b00);
    char_len_i = 2'b11;
    send(8'h3C, 0, 0);
    chk("R11 x1 data", data_o, 8'h3C);
    chk("R11 x1 ready", rx_ready_o, 1);
    pulse_read();
    // R6 odd parity mismatch, sticky through read (R10)
    setup(2'b01);
    char_len_i = 2'b10; parity_en_i = 1'b1; parity_odd_i = 1'b1;
    send(8'h55, 1, 0);
    chk("R6 parity err", parity_err_o, 1);
    chk("R6 data still delivered", data_o, 8'h55);
    pulse_read();
    chk("R10 parity sticky after read", parity_err_o, 1);
    pulse_clr();
    chk("R10 clear parity", parity_err_o, 0);
    // R7 framing error
    parity_en_i = 1'b0;
    send(8'h12, 0, 1);
    chk("R7 frame err", frame_err_o, 1);
    chk("R7 ready", rx_ready_o, 1);
    chk("R7 data", data_o, 8'h12);
    pulse_clr();
    chk("R10 clear keeps ready", rx_ready_o, 1);
    chk("R10 clear frame", frame_err_o, 0);
    pulse_read();
    // R9 overrun
    char_len_i = 2'b11;
    send(8'h81, 0, 0);
    send(8'h7E, 0, 0);
    chk("R9 overrun set", overrun_err_o, 1);
    chk("R9 data replaced", data_o, 8'h7E);
    pulse_read();
    chk("R10 overrun sticky", overrun_err_o, 1);
    pulse_clr();
    chk("R10 clear overrun", overrun_err_o, 0);
    // random frames
    for (int n = 0; n < 24; n++) begin
      setup(2'($urandom_range(0, 2)));
      char_len_i   = 2'($urandom_range(0, 3));
      parity_en_i  = 1'($urandom_range(0, 1));
      parity_odd_i = 1'($urandom_range(0, 1));
      d  = 8'($urandom);
      bp = parity_en_i && ($urandom_range(0, 3) == 0);
      bs = ($urandom_range(0, 4) == 0);
      send(d, bp, bs);
      chk("R4 random data", data_o, mask_char(d, char_len_i));
      chk("R8 random ready", rx_ready_o, 1);
      chk("R6 random parity", parity_err_o, bp);
      chk("R7 random frame", frame_err_o, bs);
      chk("R9 random no overrun", overrun_err_o, 0);
      pulse_read();
      pulse_clr();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule